// File: doc/BRIEF.md
# I2C Register-Access Slave with Pointer Auto-Increment

This block is an I2C target that gives a bus host byte-wide read and write access to a register file held elsewhere on the chip. It samples SCL and SDA with the system clock. It drives SDA only through an open-drain style low-enable and never holds SCL. A write transfer carries a register-address byte and then any number of data bytes. A read transfer first sets the pointer with a short write, then issues a repeated START with the read bit, and the host clocks data out.

The seven-bit bus address has two parts. The upper six bits come from an identity register at register address 0x00, which the host may rewrite. The lowest bit comes from a strap input, so two devices can share one bus. The identity register lives inside the block. All other register addresses go out on a simple strobe port: a one-cycle write strobe, and a one-cycle read strobe for every byte fetched, so that read side effects in the register file fire exactly once per byte. During bursts the pointer steps forward after each byte, except inside a reserved address window, where it holds.

Top module: `i2c_regport_slave`

## Requirements
- R1: After reset, sda_oe is 0, reg_wr and reg_rd are 0, and register 0x00 reads 0x68.
- R2: The slave acknowledges an address byte only when its bits 7:1 equal {identity bits 6:1, addr_lsb_i}. Bit 0 selects write (0) or read (1). Any other address gets a NACK and causes no strobe.
- R3: In a write transfer, the byte after the address loads the pointer. Each later data byte is acknowledged and produces one reg_wr pulse, with reg_addr equal to the pointer and reg_wdata equal to the byte. The pointer then advances.
- R4: A data byte written to register 0x00 updates the identity bits 6:1 from data bits 6:1 and produces no reg_wr. Register 0x00 reads as {0, identity bits 6:1, 0}. The next transfer must use the new address.
- R5: After an acknowledged address with the read bit, bytes go out MSB first, starting at the pointer. Each byte comes from one reg_rd pulse, and reg_rdata is sampled in the cycle after that pulse. A host ACK advances the pointer and fetches the next byte. A host NACK ends the fetching.
- R6: The pointer advances by one, wrapping from 0xFF to 0x00, unless its value lies in 35..60 inclusive, in which case it keeps its value.
- R7: A STOP always returns the slave to idle. A START seen after 1 to 7 bits of a byte also returns it to idle, and the slave then ignores bytes until the next START. Neither case writes anything, and the pointer keeps its value. A START at a byte boundary acts as a repeated START.
- R8: sda_oe changes only while the synchronised SCL is low. An ACK from the slave holds SDA low through the whole high phase of the ninth clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL level seen on the bus |
| sda_i | input | 1 | SDA level seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| addr_lsb_i | input | 1 | Strap that sets bit 0 of the bus address |
| reg_addr | output | 8 | Register address of the current strobe |
| reg_wdata | output | 8 | Data for reg_wr |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle read strobe, one per fetched byte |
| reg_rdata | input | 8 | Read data, valid the cycle after reg_rd |

## Verification
A wrong bit count or a wrong state shows up within the same byte. The ACK lands on the wrong clock, or the slave fails to drive it, so the host's ninth-bit sample is already wrong before the next byte starts. A corrupted pointer or a wrong increment rule stays hidden on the bus until the next strobe. It then appears as a wrong reg_addr on reg_wr or reg_rd, or as read data taken from another register, so the bench compares every strobe address and every returned byte with a pointer model of its own. A stale identity value shows only in the next transfer's address phase, so each identity write is followed at once by probes at both the old and the new address.

// File: rtl/i2cs_pkg.sv
`timescale 1ns/1ps
package i2cs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_REGA,
    ST_WDAT,
    ST_ACK,
    ST_RDAT,
    ST_RACK
  } state_t;

  // Pointer step: hold inside the reserved window, otherwise +1 with wrap.
  function automatic logic [7:0] next_ptr(logic [7:0] p, logic [7:0] lo, logic [7:0] hi);
    if (p >= lo && p <= hi) return p;
    return p + 8'd1;
  endfunction

  // Byte returned when register 0 is read.
  function automatic logic [7:0] id_readback(logic [5:0] id);
    return {1'b0, id, 1'b0};
  endfunction

endpackage

// File: rtl/i2cs_sync.sv
`timescale 1ns/1ps
module i2cs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  localparam int NLINE = 2;

  logic [NLINE-1:0] raw;
  logic [NLINE-1:0] line_s;
  logic [NLINE-1:0] line_q;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < NLINE; g++) begin : g_line
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '1;
      else        pipe <= {pipe[STAGES-2:0], raw[g]};
    end
    assign line_s[g] = pipe[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '1;
    else        line_q <= line_s;
  end

  assign scl_s     = line_s[1];
  assign sda_s     = line_s[0];
  assign scl_rise  =  line_s[1] & ~line_q[1];
  assign scl_fall  = ~line_s[1] &  line_q[1];
  assign start_evt =  line_s[1] & line_q[1] &  line_q[0] & ~line_s[0];
  assign stop_evt  =  line_s[1] & line_q[1] & ~line_q[0] &  line_s[0];

endmodule

// File: rtl/i2cs_idreg.sv
`timescale 1ns/1ps
module i2cs_idreg
  import i2cs_pkg::*;
#(
  parameter logic [5:0] ID_RESET = 6'b110100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       id_we,
  input  logic [5:0] id_wdata,
  input  logic       strap,
  output logic [6:0] dev_addr,
  output logic [7:0] id_byte
);
  logic [5:0] id_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     id_q <= ID_RESET;
    else if (id_we) id_q <= id_wdata;
  end

  assign dev_addr = {id_q, strap};
  assign id_byte  = id_readback(id_q);

  // R4: identity changes only through the write strobe
  assert_id_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !id_we |=> $stable(id_q));

endmodule

// File: rtl/i2cs_engine.sv
`timescale 1ns/1ps
module i2cs_engine
  import i2cs_pkg::*;
#(
  parameter logic [7:0] RSV_LO = 8'd35,
  parameter logic [7:0] RSV_HI = 8'd60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_evt,
  input  logic       stop_evt,
  input  logic [6:0] dev_addr,
  input  logic [7:0] id_byte,
  input  logic [7:0] reg_rdata,
  output logic       sda_oe,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_wr,
  output logic       reg_rd,
  output logic       id_we
);
  localparam logic [2:0] LAST_BIT = 3'd7;

  state_t     st_q, after_q;
  logic [2:0] cnt_q;
  logic       got_rise_q, bit_q;
  logic [7:0] sh_q, tx_q, ptr_q, addr_q, wdata_q;
  logic       wr_q, rd_q, load_q, idwe_q;

  // Named internal events
  logic       bit_done, rx_state, byte_done, addr_hit, ptr_load, fetch_busy;
  logic [7:0] byte_in, ptr_step;

  assign bit_done   = scl_fall & got_rise_q;
  assign rx_state   = (st_q == ST_ADDR) || (st_q == ST_REGA) || (st_q == ST_WDAT);
  assign byte_done  = bit_done & rx_state & (cnt_q == LAST_BIT);
  assign byte_in    = {sh_q[6:0], bit_q};
  assign addr_hit   = (byte_in[7:1] == dev_addr);
  assign ptr_load   = byte_done & (st_q == ST_REGA);
  assign ptr_step   = next_ptr(ptr_q, RSV_LO, RSV_HI);
  assign fetch_busy = rd_q | load_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      after_q    <= ST_IDLE;
      cnt_q      <= '0;
      got_rise_q <= 1'b0;
      bit_q      <= 1'b1;
      sh_q       <= '0;
      tx_q       <= '1;
      ptr_q      <= '0;
      addr_q     <= '0;
      wdata_q    <= '0;
      wr_q       <= 1'b0;
      rd_q       <= 1'b0;
      load_q     <= 1'b0;
      idwe_q     <= 1'b0;
    end else begin
      wr_q   <= 1'b0;
      rd_q   <= 1'b0;
      idwe_q <= 1'b0;
      load_q <= rd_q;
      if (load_q) tx_q <= (addr_q == 8'd0) ? id_byte : reg_rdata;
      if (scl_rise) begin
        bit_q      <= sda_s;
        got_rise_q <= 1'b1;
      end
      if (stop_evt) begin
        st_q       <= ST_IDLE;
        cnt_q      <= '0;
        got_rise_q <= 1'b0;
      end else if (start_evt) begin
        st_q       <= (cnt_q == 3'd0) ? ST_ADDR : ST_IDLE;
        cnt_q      <= '0;
        got_rise_q <= 1'b0;
      end else if (bit_done) begin
        got_rise_q <= 1'b0;
        unique case (st_q)
          ST_ADDR, ST_REGA, ST_WDAT: begin
            sh_q  <= byte_in;
            cnt_q <= cnt_q + 3'd1;
            if (cnt_q == LAST_BIT) begin
              unique case (st_q)
                ST_ADDR: begin
                  if (addr_hit) begin
                    st_q    <= ST_ACK;
                    after_q <= byte_in[0] ? ST_RDAT : ST_REGA;
                    if (byte_in[0]) begin
                      rd_q   <= 1'b1;
                      addr_q <= ptr_q;
                    end
                  end else begin
                    st_q <= ST_IDLE;
                  end
                end
                ST_REGA: begin
                  st_q    <= ST_ACK;
                  after_q <= ST_WDAT;
                  ptr_q   <= byte_in;
                end
                default: begin
                  st_q    <= ST_ACK;
                  after_q <= ST_WDAT;
                  addr_q  <= ptr_q;
                  wdata_q <= byte_in;
                  if (ptr_q == 8'd0) idwe_q <= 1'b1;
                  else               wr_q   <= 1'b1;
                  ptr_q   <= ptr_step;
                end
              endcase
            end
          end
          ST_ACK: begin
            st_q  <= after_q;
            cnt_q <= '0;
          end
          ST_RDAT: begin
            cnt_q <= cnt_q + 3'd1;
            tx_q  <= {tx_q[6:0], 1'b0};
            if (cnt_q == LAST_BIT) st_q <= ST_RACK;
          end
          ST_RACK: begin
            cnt_q <= '0;
            if (!bit_q) begin
              ptr_q  <= ptr_step;
              addr_q <= ptr_step;
              rd_q   <= 1'b1;
              st_q   <= ST_RDAT;
            end else begin
              st_q <= ST_IDLE;
            end
          end
          default: cnt_q <= '0;
        endcase
      end
    end
  end

  assign sda_oe    = (st_q == ST_ACK) | ((st_q == ST_RDAT) & ~tx_q[7] & ~fetch_busy);
  assign reg_addr  = addr_q;
  assign reg_wdata = wdata_q;
  assign reg_wr    = wr_q;
  assign reg_rd    = rd_q;
  assign id_we     = idwe_q;

  // R8: SDA drive may change only while SCL is low
  assert_sda_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe));

  // R3: write strobe lasts exactly one cycle
  assert_wr_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  // R5: read strobe lasts exactly one cycle
  assert_rd_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd);

  // R6: pointer inside the reserved window never moves unless reloaded
  assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_q >= RSV_LO && ptr_q <= RSV_HI && !ptr_load) |=> $stable(ptr_q));

  // R7: a STOP always lands in idle
  assert_stop_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (st_q == ST_IDLE));

endmodule

// File: rtl/i2c_regport_slave.sv
`timescale 1ns/1ps
module i2c_regport_slave #(
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] RSV_LO      = 8'd35,
  parameter logic [7:0] RSV_HI      = 8'd60,
  parameter logic [5:0] ID_RESET    = 6'b110100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       addr_lsb_i,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_wr,
  output logic       reg_rd,
  input  logic [7:0] reg_rdata
);
  logic       scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic       id_we;
  logic [6:0] dev_addr;
  logic [7:0] id_byte;

  i2cs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2cs_idreg #(.ID_RESET(ID_RESET)) u_id (
    .clk(clk), .rst_n(rst_n), .id_we(id_we), .id_wdata(reg_wdata[6:1]),
    .strap(addr_lsb_i), .dev_addr(dev_addr), .id_byte(id_byte)
  );

  i2cs_engine #(.RSV_LO(RSV_LO), .RSV_HI(RSV_HI)) u_eng (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
    .dev_addr(dev_addr), .id_byte(id_byte), .reg_rdata(reg_rdata),
    .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .id_we(id_we)
  );

endmodule

// File: tb/i2c_regport_slave_tb_top.sv
`timescale 1ns/1ps
module i2c_regport_slave_tb_top;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1, strap = 1'b0;
  logic sda_oe, reg_wr, reg_rd;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  wire sda_line = sda_m & ~sda_oe;

  i2c_regport_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_lsb_i(strap), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  function automatic logic [7:0] init_val(int i);
    return 8'(i * 7 + 3);
  endfunction

  // Register file model at the strobe port
  logic [7:0] mem [256];
  int wr_cnt, rd_cnt;
  logic [7:0] wlog_a [16], wlog_d [16], rlog_a [16];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
      wr_cnt <= 0; rd_cnt <= 0; reg_rdata <= 8'h00;
    end else begin
      if (reg_wr) begin
        mem[reg_addr] <= reg_wdata;
        wlog_a[wr_cnt % 16] <= reg_addr;
        wlog_d[wr_cnt % 16] <= reg_wdata;
        wr_cnt <= wr_cnt + 1;
      end
      if (reg_rd) begin
        reg_rdata <= mem[reg_addr];
        rlog_a[rd_cnt % 16] <= reg_addr;
        rd_cnt <= rd_cnt + 1;
      end
    end
  end

  int checks = 0, errors = 0;
  logic [7:0] shadow [256];
  logic [5:0] dev6 = 6'b110100;
  logic [7:0] bptr = 8'h00;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] bnext(logic [7:0] p);
    if (p < 8'd35 || p > 8'd60) return p + 8'd1;
    return p;
  endfunction

  function automatic logic [7:0] exp_reg(logic [7:0] a);
    if (a == 8'd0) return {1'b0, dev6, 1'b0};
    return shadow[a];
  endfunction

  function automatic int exp_ack(logic [6:0] dev);
    return (dev == {dev6, strap}) ? 1 : 0;
  endfunction

  task automatic wait_q(int n); repeat (n * Q) @(negedge clk); endtask
  task automatic bus_start(); sda_m = 1; scl_m = 1; wait_q(1); sda_m = 0; wait_q(1); scl_m = 0; wait_q(1); endtask
  task automatic bus_rstart(); sda_m = 1; wait_q(1); scl_m = 1; wait_q(1); sda_m = 0; wait_q(1); scl_m = 0; wait_q(1); endtask
  task automatic bus_stop(); sda_m = 0; wait_q(1); scl_m = 1; wait_q(1); sda_m = 1; wait_q(1); endtask
  task automatic put_bit(logic v); sda_m = v; wait_q(1); scl_m = 1; wait_q(2); scl_m = 0; wait_q(1); endtask
  task automatic get_bit(output logic v);
    sda_m = 1; wait_q(1); scl_m = 1; wait_q(1); v = sda_line; wait_q(1); scl_m = 0; wait_q(1);
  endtask
  task automatic put_byte(logic [7:0] b, output logic ack);
    logic nak;
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(nak);
    ack = ~nak;
  endtask
  task automatic get_byte(logic ack, output logic [7:0] b);
    logic x;
    for (int i = 7; i >= 0; i--) begin get_bit(x); b[i] = x; end
    put_bit(~ack);
  endtask

  task automatic wr_txn(string tag, logic [6:0] dev, logic [7:0] ra, int n, logic [7:0] seed);
    int w0, nexp;
    logic a;
    logic [7:0] d;
    logic [7:0] ea [8];
    logic [7:0] ed [8];
    w0 = wr_cnt; nexp = 0;
    bus_start;
    put_byte({dev, 1'b0}, a); check(tag, a, 1);
    put_byte(ra, a); check(tag, a, 1);
    bptr = ra;
    for (int k = 0; k < n; k++) begin
      d = seed + 8'(k * 59);
      put_byte(d, a); check(tag, a, 1);
      if (bptr == 8'd0) dev6 = d[6:1];
      else begin shadow[bptr] = d; ea[nexp] = bptr; ed[nexp] = d; nexp++; end
      bptr = bnext(bptr);
    end
    bus_stop;
    wait_q(1);
    check(tag, wr_cnt - w0, nexp);
    for (int k = 0; k < nexp; k++) begin
      check(tag, wlog_a[(w0 + k) % 16], ea[k]);
      check(tag, wlog_d[(w0 + k) % 16], ed[k]);
    end
  endtask

  task automatic rd_txn(string tag, logic [6:0] dev, logic set_ptr, logic [7:0] ra, int n);
    int r0;
    logic a;
    logic [7:0] b;
    logic [7:0] ea [8];
    r0 = rd_cnt;
    bus_start;
    if (set_ptr) begin
      put_byte({dev, 1'b0}, a); check(tag, a, 1);
      put_byte(ra, a); check(tag, a, 1);
      bptr = ra;
      bus_rstart;
    end
    put_byte({dev, 1'b1}, a); check(tag, a, 1);
    for (int k = 0; k < n; k++) begin
      ea[k] = bptr;
      get_byte(k < n - 1, b);
      check(tag, b, exp_reg(ea[k]));
      if (k < n - 1) bptr = bnext(bptr);
    end
    bus_stop;
    wait_q(1);
    check(tag, rd_cnt - r0, n);
    for (int k = 0; k < n; k++) check(tag, rlog_a[(r0 + k) % 16], ea[k]);
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic a;
    int w0, r0;
    for (int i = 0; i < 256; i++) shadow[i] = init_val(i);
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 sda_oe", sda_oe, 0);
    check("R1 strobes", {reg_wr, reg_rd}, 0);
    rd_txn("R1 identity", 7'h68, 1'b1, 8'h00, 1);

    // R2 full address sweep for both strap levels
    for (int s = 0; s < 2; s++) begin
      strap = s[0];
      wait_q(1);
      w0 = wr_cnt; r0 = rd_cnt;
      for (int ad = 0; ad < 128; ad++) begin
        bus_start;
        put_byte({ad[6:0], 1'b0}, a);
        bus_stop;
        check("R2 ack", a, exp_ack(ad[6:0]));
      end
      check("R2 no strobes", (wr_cnt - w0) + (rd_cnt - r0), 0);
    end
    strap = 0;
    wait_q(1);

    // R3 single and burst writes
    wr_txn("R3 single", 7'h68, 8'h10, 1, 8'hA5);
    wr_txn("R3 burst", 7'h68, 8'h20, 4, 8'h3C);
    // R5 burst read over written and untouched registers
    rd_txn("R5 burst", 7'h68, 1'b1, 8'h20, 5);
    rd_txn("R5 single", 7'h68, 1'b1, 8'h10, 1);

    // R6 pointer hold in reserved window and wrap
    wr_txn("R6 write edge", 7'h68, 8'd33, 4, 8'h71);
    rd_txn("R6 read hold", 7'h68, 1'b1, 8'd58, 3);
    rd_txn("R6 read wrap", 7'h68, 1'b1, 8'hFE, 3);
    rd_txn("R6 read above", 7'h68, 1'b1, 8'd60, 3);

    // R7 STOP in the middle of a data byte
    w0 = wr_cnt;
    bus_start;
    put_byte(8'hD0, a); check("R7 stop abort", a, 1);
    put_byte(8'h40, a); check("R7 stop abort", a, 1);
    bptr = 8'h40;
    put_bit(1); put_bit(0); put_bit(1);
    bus_stop;
    wait_q(1);
    check("R7 stop no write", wr_cnt - w0, 0);
    rd_txn("R7 ptr kept", 7'h68, 1'b0, 8'h00, 1);

    // R7 START in the middle of a data byte
    w0 = wr_cnt;
    bus_start;
    put_byte(8'hD0, a); check("R7 start abort", a, 1);
    put_byte(8'h50, a); check("R7 start abort", a, 1);
    bptr = 8'h50;
    put_bit(0); put_bit(1);
    bus_rstart;
    put_byte(8'hD1, a); check("R7 idle ignores", a, 0);
    bus_stop;
    wait_q(1);
    check("R7 start no write", wr_cnt - w0, 0);
    rd_txn("R7 ptr kept2", 7'h68, 1'b0, 8'h00, 2);

    // R4 identity rewrite, bit 7 ignored
    w0 = wr_cnt;
    wr_txn("R4 id write", 7'h68, 8'h00, 1, 8'h8A);
    check("R4 no reg_wr", wr_cnt - w0, 0);
    bus_start; put_byte(8'hD0, a); bus_stop;
    check("R4 old addr nack", a, 0);
    rd_txn("R4 new addr", 7'h0A, 1'b1, 8'h00, 2);
    wr_txn("R4 restore", 7'h0A, 8'h00, 1, 8'h68);
    strap = 1;
    wait_q(1);
    rd_txn("R4 strap one", 7'h69, 1'b1, 8'h00, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule